// File: doc/BRIEF.md
# Remapped Scanline Scanout with Hardware Cursor

The block turns one screen line into a serial monochrome pixel stream, 1024 pixels wide, each time it is asked to. Every screen line goes through a remap table with 1024 entries. The entry names the buffer line in video memory that supplies the pixels. Because of this, software can scroll, duplicate or reorder the display by rewriting table entries instead of moving framebuffer data. Video memory sits outside the block and is reached through a plain synchronous read port. The block fetches one 32-bit word per 32 pixels and prefetches the next word, which hides the port's one-cycle latency.

A 16x16 one-bit cursor image is held inside the block and merged into the stream. The cursor's top line comes from character-cell arithmetic: a row number times the cell height (the maximum scan index plus one), plus a start-scan offset. One bit of the start-scan value hides the cursor. A mode input chooses how the cursor combines with the framebuffer: it either sets pixels (OR) or clears them (AND-NOT). An outside timing generator decides when each line is requested. The cursor and remap settings in force when a request is accepted apply to the whole of that line.

Top module: `lmap_scanout`

## Requirements
- R1: After reset `busy`, `pix_valid`, `pix_sol` and `mem_rd_en` are 0. Every remap entry n holds buffer line n, so the display is an identity mapping. The cursor image is all zeros.
- R2: Pixel column c of a line whose buffer line is B comes from bit (c mod 32) of the memory word at address B*32 + c/32, where the address is buffer line in bits 15:5 and word index in bits 4:0. Bit 0 is the leftmost pixel of each word.
- R3: A line request for screen line L fetches the buffer line stored in remap entry L. Remap writes made before the request take effect on that line.
- R4: A remap write addresses a pair p of screen lines. When `map_wr_half[0]` is set, entry 2p takes `map_wr_data[10:0]`. When `map_wr_half[1]` is set, entry 2p+1 takes `map_wr_data[26:16]`. A write with only one half bit set leaves the other entry of the pair unchanged. All other data bits are ignored.
- R5: A request is accepted on a rising edge where `line_req` is 1 and `busy` is 0. The first pixel, marked by `pix_sol`, appears 3 cycles after the accepting edge. It is followed by exactly 1024 consecutive `pix_valid` cycles, and `pix_sol` is asserted only on the first of them.
- R6: Each line issues exactly 32 memory reads and none while idle. A read issued in one cycle has its data on `mem_rd_data` in the next cycle.
- R7: A `line_req` that arrives while `busy` is 1 is ignored. It neither restarts nor lengthens the line in progress, and no second line follows it.
- R8: The cursor top line is `cur_row_hi*(cur_cell_max+1)+cur_start`. Screen line top+r (0 ≤ r < 16) uses cursor image row r. Column `cur_x`+i uses bit i of that row. Image row k is written through `cimg_wr_row`=k.
- R9: The cursor is shown only when bit 5 of `cur_start` is 0. When that bit is 1 the line equals the framebuffer pixels.
- R10: Inside the cursor window, when `cur_or_mode` is 1 the pixel is the framebuffer bit OR the cursor bit. When it is 0 the pixel is the framebuffer bit AND NOT the cursor bit.
- R11: Cursor columns at X ≥ 1024 are dropped and do not wrap to the start of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Remap table write strobe |
| map_wr_pair | input | 9 | Screen-line pair index of the remap write |
| map_wr_data | input | 32 | Remap write data (even line low half, odd line high half) |
| map_wr_half | input | 2 | Half enables: bit 0 even line, bit 1 odd line |
| cimg_wr_en | input | 1 | Cursor image write strobe |
| cimg_wr_row | input | 4 | Cursor image row written |
| cimg_wr_data | input | 16 | Cursor row bits, bit i for column offset i |
| cur_x | input | 10 | Cursor left column |
| cur_row_hi | input | 8 | Cursor character row |
| cur_cell_max | input | 5 | Maximum scan index within a character cell |
| cur_start | input | 8 | Cursor start scan; bit 5 hides the cursor |
| cur_or_mode | input | 1 | 1 = OR merge, 0 = AND-NOT merge |
| line_req | input | 1 | Request to scan out one screen line |
| line_num | input | 10 | Screen line of the request |
| mem_rd_en | output | 1 | Video memory read strobe |
| mem_rd_addr | output | 16 | Video memory word address |
| mem_rd_data | input | 32 | Video memory data, one cycle after the read |
| busy | output | 1 | A line is in progress |
| pix_valid | output | 1 | Pixel output is valid |
| pix_out | output | 1 | Pixel value |
| pix_sol | output | 1 | First pixel of the line |

## Verification
The hardest case to reach is the cursor edge: a window that straddles the right border of the line, and lines exactly at the cursor's first and last rows and one past them. Each depends on products of the cell arithmetic landing on a chosen line. The stimulus table picks row, cell height and start-scan values so that the top lands on the requested line, on the line 15 below it and on the line 16 below it. One vector places the window at column 1020, and another uses a start-scan value that hits the line but has the hide bit set. A request dropped into the middle of a line, and remap writes that change only one half of a pair, cover the ignore and partial-write cases.

// File: rtl/lmap_pkg.sv
package lmap_pkg;
    localparam int LINE_PIX      = 1024;
    localparam int WORD_W        = 32;
    localparam int SCREEN_LINES  = 1024;
    localparam int BUF_LINE_W    = 11;
    localparam int CUR_DIM       = 16;
    localparam int HIDE_BIT      = 5;
    localparam int HALF_W        = WORD_W / 2;

    localparam int COL_W   = $clog2(LINE_PIX);
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int WIDX_W  = COL_W - BIT_W;
    localparam int LINE_W  = $clog2(SCREEN_LINES);
    localparam int ADDR_W  = BUF_LINE_W + WIDX_W;
    localparam int CROW_W  = $clog2(CUR_DIM);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIME,
        ST_LOAD,
        ST_RUN
    } fetch_st_t;

    typedef struct packed {
        logic               on;
        logic               or_mode;
        logic [COL_W-1:0]   x;
        logic [CUR_DIM-1:0] bits;
    } cur_line_t;

    function automatic logic merge_pix(input logic fb, input logic cb, input logic or_mode);
        return or_mode ? (fb | cb) : (fb & ~cb);
    endfunction
endpackage

// File: rtl/lmap_table.sv
module lmap_table
    import lmap_pkg::*;
#(
    parameter int LINES   = SCREEN_LINES,
    parameter int ENTRY_W = BUF_LINE_W,
    parameter int DATA_W  = WORD_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(LINES)-2:0]   wr_pair,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [1:0]                 wr_half,
    input  logic [$clog2(LINES)-1:0]   rd_line,
    output logic [ENTRY_W-1:0]         rd_entry
);
    localparam int HW = DATA_W / 2;

    logic [ENTRY_W-1:0] tbl [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < LINES; n++) begin
                tbl[n] <= ENTRY_W'(n);
            end
        end else if (wr_en) begin
            if (wr_half[0]) tbl[{wr_pair, 1'b0}] <= wr_data[ENTRY_W-1:0];
            if (wr_half[1]) tbl[{wr_pair, 1'b1}] <= wr_data[HW+ENTRY_W-1:HW];
        end
    end

    assign rd_entry = tbl[rd_line];
endmodule

// File: rtl/lmap_cursor.sv
module lmap_cursor
    import lmap_pkg::*;
#(
    parameter int DIM   = CUR_DIM,
    parameter int TOP_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               img_wr_en,
    input  logic [CROW_W-1:0]  img_wr_row,
    input  logic [DIM-1:0]     img_wr_data,
    input  logic [COL_W-1:0]   cur_x,
    input  logic [7:0]         row_hi,
    input  logic [4:0]         cell_max,
    input  logic [7:0]         start_scan,
    input  logic               or_mode,
    input  logic               capture,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [COL_W-1:0]   col,
    input  logic               fb_pix,
    output logic               out_pix
);
    logic [DIM-1:0]   img [DIM];
    logic [TOP_W-1:0] top_line;
    logic [TOP_W-1:0] offs;
    logic             row_hit;
    cur_line_t        cap;
    logic [COL_W:0]   dx;
    logic             in_win;
    logic             cb;

    always_comb begin
        top_line = TOP_W'(row_hi) * (TOP_W'(cell_max) + TOP_W'(1)) + TOP_W'(start_scan);
        offs     = TOP_W'(line_num) - top_line;
        row_hit  = !start_scan[HIDE_BIT] && (TOP_W'(line_num) >= top_line)
                   && (offs < TOP_W'(DIM));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < DIM; r++) begin
                img[r] <= '0;
            end
            cap <= '0;
        end else begin
            if (img_wr_en) img[img_wr_row] <= img_wr_data;
            if (capture) begin
                cap.on      <= row_hit;
                cap.or_mode <= or_mode;
                cap.x       <= cur_x;
                cap.bits    <= img[offs[CROW_W-1:0]];
            end
        end
    end

    always_comb begin
        dx      = {1'b0, col} - {1'b0, cap.x};
        in_win  = cap.on && !dx[COL_W] && (dx < (COL_W+1)'(DIM));
        cb      = cap.bits[dx[CROW_W-1:0]];
        out_pix = in_win ? merge_pix(fb_pix, cb, cap.or_mode) : fb_pix;
    end
endmodule

// File: rtl/lmap_fetch.sv
module lmap_fetch
    import lmap_pkg::*;
#(
    parameter int BL_W = BUF_LINE_W,
    parameter int W    = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [BL_W-1:0]      bufline_in,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic [W-1:0]         mem_rd_data,
    output logic                 busy,
    output logic                 run,
    output logic [COL_W-1:0]     col,
    output logic                 fb_pix
);
    fetch_st_t          st;
    logic [BL_W-1:0]    bl;
    logic [COL_W-1:0]   pcnt;
    logic [W-1:0]       shreg;
    logic [WIDX_W-1:0]  nxt_word;
    logic               last_bit;
    logic               last_word;

    assign last_bit  = (pcnt[BIT_W-1:0] == BIT_W'(W-1));
    assign last_word = (pcnt[COL_W-1:BIT_W] == {WIDX_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            bl    <= '0;
            pcnt  <= '0;
            shreg <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        bl <= bufline_in;
                        st <= ST_PRIME;
                    end
                end
                ST_PRIME: st <= ST_LOAD;
                ST_LOAD: begin
                    shreg <= mem_rd_data;
                    pcnt  <= '0;
                    st    <= ST_RUN;
                end
                ST_RUN: begin
                    pcnt <= pcnt + 1'b1;
                    if (last_bit) begin
                        if (last_word) st <= ST_IDLE;
                        else           shreg <= mem_rd_data;
                    end else begin
                        shreg <= shreg >> 1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        nxt_word    = (st == ST_PRIME) ? '0 : pcnt[COL_W-1:BIT_W] + 1'b1;
        mem_rd_addr = {bl, nxt_word};
        mem_rd_en   = (st == ST_PRIME) ||
                      ((st == ST_RUN) && (pcnt[BIT_W-1:0] == BIT_W'(W-2)) && !last_word);
        busy        = (st != ST_IDLE);
        run         = (st == ST_RUN);
        col         = pcnt;
        fb_pix      = shreg[0];
    end
endmodule

// File: rtl/lmap_scanout.sv
module lmap_scanout
    import lmap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  map_wr_en,
    input  logic [LINE_W-2:0]     map_wr_pair,
    input  logic [WORD_W-1:0]     map_wr_data,
    input  logic [1:0]            map_wr_half,
    input  logic                  cimg_wr_en,
    input  logic [CROW_W-1:0]     cimg_wr_row,
    input  logic [CUR_DIM-1:0]    cimg_wr_data,
    input  logic [COL_W-1:0]      cur_x,
    input  logic [7:0]            cur_row_hi,
    input  logic [4:0]            cur_cell_max,
    input  logic [7:0]            cur_start,
    input  logic                  cur_or_mode,
    input  logic                  line_req,
    input  logic [LINE_W-1:0]     line_num,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic [WORD_W-1:0]     mem_rd_data,
    output logic                  busy,
    output logic                  pix_valid,
    output logic                  pix_out,
    output logic                  pix_sol
);
    logic [BUF_LINE_W-1:0] entry;
    logic                  accept;
    logic                  run;
    logic [COL_W-1:0]      col;
    logic                  fb_pix;

    assign accept = line_req && !busy;

    lmap_table #(
        .LINES   (SCREEN_LINES),
        .ENTRY_W (BUF_LINE_W),
        .DATA_W  (WORD_W)
    ) i_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (map_wr_en),
        .wr_pair  (map_wr_pair),
        .wr_data  (map_wr_data),
        .wr_half  (map_wr_half),
        .rd_line  (line_num),
        .rd_entry (entry)
    );

    lmap_fetch #(
        .BL_W (BUF_LINE_W),
        .W    (WORD_W)
    ) i_fetch (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .bufline_in  (entry),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .busy        (busy),
        .run         (run),
        .col         (col),
        .fb_pix      (fb_pix)
    );

    lmap_cursor #(
        .DIM   (CUR_DIM),
        .TOP_W (16)
    ) i_cursor (
        .clk         (clk),
        .rst         (rst),
        .img_wr_en   (cimg_wr_en),
        .img_wr_row  (cimg_wr_row),
        .img_wr_data (cimg_wr_data),
        .cur_x       (cur_x),
        .row_hi      (cur_row_hi),
        .cell_max    (cur_cell_max),
        .start_scan  (cur_start),
        .or_mode     (cur_or_mode),
        .capture     (accept),
        .line_num    (line_num),
        .col         (col),
        .fb_pix      (fb_pix),
        .out_pix     (pix_out)
    );

    assign pix_valid = run;
    assign pix_sol   = run && (col == '0);
endmodule

// File: rtl/lmap_checker.sv
module lmap_checker
    import lmap_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic line_req,
    input logic busy,
    input logic mem_rd_en,
    input logic pix_valid,
    input logic pix_sol
);
    logic [COL_W:0] vcnt;
    logic [7:0]     rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt <= '0;
            rcnt <= '0;
        end else begin
            if (pix_sol)        vcnt <= (COL_W+1)'(1);
            else if (pix_valid) vcnt <= vcnt + 1'b1;
            if (line_req && !busy) rcnt <= '0;
            else if (mem_rd_en)    rcnt <= rcnt + 1'b1;
        end
    end

    p_idle_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en);

    p_sol_in_line_r5: assert property (@(posedge clk) disable iff (rst)
        pix_sol |-> pix_valid);

    p_first_is_sol_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_valid) |-> pix_sol);

    p_sol_single_r5: assert property (@(posedge clk) disable iff (rst)
        pix_sol |=> !pix_sol);

    p_line_length_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_valid) |-> (vcnt == (COL_W+1)'(LINE_PIX)));

    p_read_count_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_valid) |-> (rcnt == 8'(LINE_PIX / WORD_W)));
endmodule

bind lmap_scanout lmap_checker i_lmap_checker (
    .clk       (clk),
    .rst       (rst),
    .line_req  (line_req),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .pix_valid (pix_valid),
    .pix_sol   (pix_sol)
);

// File: tb/test_lmap_scanout.sv
`timescale 1ns/1ps
module test_lmap_scanout;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_wr_en = 1'b0;
    logic [8:0]  map_wr_pair = '0;
    logic [31:0] map_wr_data = '0;
    logic [1:0]  map_wr_half = '0;
    logic        cimg_wr_en = 1'b0;
    logic [3:0]  cimg_wr_row = '0;
    logic [15:0] cimg_wr_data = '0;
    logic [9:0]  cur_x = '0;
    logic [7:0]  cur_row_hi = '0;
    logic [4:0]  cur_cell_max = '0;
    logic [7:0]  cur_start = 8'h20;
    logic        cur_or_mode = 1'b0;
    logic        line_req = 1'b0;
    logic [9:0]  line_num = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        busy, pix_valid, pix_out, pix_sol;

    int total = 0;
    int bad = 0;
    int map_m [1024];
    logic [15:0] cimg_m [16];

    always #5 clk = ~clk;

    lmap_scanout i_lmap_scanout (
        .clk(clk), .rst(rst),
        .map_wr_en(map_wr_en), .map_wr_pair(map_wr_pair),
        .map_wr_data(map_wr_data), .map_wr_half(map_wr_half),
        .cimg_wr_en(cimg_wr_en), .cimg_wr_row(cimg_wr_row), .cimg_wr_data(cimg_wr_data),
        .cur_x(cur_x), .cur_row_hi(cur_row_hi), .cur_cell_max(cur_cell_max),
        .cur_start(cur_start), .cur_or_mode(cur_or_mode),
        .line_req(line_req), .line_num(line_num),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .busy(busy), .pix_valid(pix_valid), .pix_out(pix_out), .pix_sol(pix_sol)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ {16'hA5C3, a};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);
    end

    function automatic logic exp_pix(input int ln, input int c);
        logic [15:0] a;
        logic fb, cb;
        int top;
        a   = {map_m[ln][10:0], 5'(c / 32)};
        fb  = mem_word(a)[c % 32];
        top = int'(cur_row_hi) * (int'(cur_cell_max) + 1) + int'(cur_start);
        if (!cur_start[5] && ln >= top && ln < top + 16 && c >= int'(cur_x) && c < int'(cur_x) + 16) begin
            cb = cimg_m[ln - top][c - int'(cur_x)];
            return cur_or_mode ? (fb | cb) : (fb & ~cb);
        end
        return fb;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic scan_line(input int ln, input string req, input bit inject);
        int w = 0;
        int rd = 0;
        int errs = 0;
        int first_c = -1;
        int first_a = 0;
        int first_e = 0;
        int nvalid = 0;
        int nsol = 0;
        logic e;
        line_num = 10'(ln);
        line_req = 1'b1;
        do begin
            @(negedge clk);
            line_req = 1'b0;
            w++;
            if (mem_rd_en) rd++;
        end while (!pix_sol && w < 20);
        chk(w == 3, "R5", "first pixel delay", w, 3);
        for (int c = 0; c < 1024; c++) begin
            if (c > 0) begin
                @(negedge clk);
                if (mem_rd_en) rd++;
                line_req = 1'b0;
            end
            if (pix_valid) nvalid++;
            if (pix_sol) nsol++;
            e = exp_pix(ln, c);
            if (pix_out !== e || pix_valid !== 1'b1) begin
                if (first_c < 0) begin
                    first_c = c; first_a = int'(pix_out); first_e = int'(e);
                end
                errs++;
            end
            if (inject && c == 100) begin
                line_num = 10'd9;
                line_req = 1'b1;
            end
        end
        chk(errs == 0, req, $sformatf("line %0d pixel col %0d", ln, first_c), first_a, first_e);
        chk(nvalid == 1024 && nsol == 1, "R5", "valid/sol count", nvalid * 10 + nsol, 10241);
        chk(rd == 32, "R6", "reads per line", rd, 32);
        @(negedge clk);
        chk(!pix_valid && !busy, "R7", "line ends", int'(pix_valid), 0);
        if (inject) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (pix_valid || busy) nvalid++;
            end
            chk(nvalid == 1024, "R7", "no line after ignored request", nvalid, 1024);
        end
        line_num = 10'(ln);
    endtask

    task automatic map_write(input int pair, input logic [31:0] d, input logic [1:0] h);
        map_wr_pair = 9'(pair); map_wr_data = d; map_wr_half = h; map_wr_en = 1'b1;
        @(negedge clk);
        map_wr_en = 1'b0;
        if (h[0]) map_m[2 * pair]     = int'(d[10:0]);
        if (h[1]) map_m[2 * pair + 1] = int'(d[26:16]);
    endtask

    // line, cur_x, row_hi, cell_max, start, or_mode
    localparam int VEC [0:5][0:5] = '{
        '{5,    100, 0,  0,  0,  1},   // R8 R10 top 0, row 5, OR
        '{40,   7,   3,  11, 4,  0},   // R8 R10 top 40, row 0, AND-NOT
        '{55,   7,   3,  11, 4,  1},   // R8 last cursor row
        '{56,   7,   3,  11, 4,  1},   // R8 one line below cursor
        '{300,  1020, 10, 29, 0, 1},   // R11 clipped at right edge
        '{300,  500, 8,  29, 60, 1}    // R9 hide bit set on a hitting line
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int n = 0; n < 1024; n++) map_m[n] = n;
        for (int r = 0; r < 16; r++) cimg_m[r] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !pix_valid && !pix_sol && !mem_rd_en, "R1", "idle after reset",
            int'({busy, pix_valid, pix_sol, mem_rd_en}), 0);
        // R1 identity map, R2 pixel order, cursor hidden
        scan_line(1023, "R1", 1'b0);
        // R1 cleared image: cursor visible but empty, OR mode leaves pixels
        cur_start = 8'h0; cur_or_mode = 1'b1; cur_x = 10'd0;
        scan_line(3, "R1", 1'b0);

        for (int r = 0; r < 16; r++) begin
            cimg_m[r] = 16'h8001 | (16'h1 << r) | 16'(r * 16'h0123);
            cimg_wr_row = 4'(r); cimg_wr_data = cimg_m[r]; cimg_wr_en = 1'b1;
            @(negedge clk);
        end
        cimg_wr_en = 1'b0;

        for (int v = 0; v < 6; v++) begin
            cur_x        = 10'(VEC[v][1]);
            cur_row_hi   = 8'(VEC[v][2]);
            cur_cell_max = 5'(VEC[v][3]);
            cur_start    = 8'(VEC[v][4]);
            cur_or_mode  = VEC[v][5][0];
            scan_line(VEC[v][0], (v == 4) ? "R11" : (v == 5) ? "R9" : (v == 1) ? "R10" : "R8", 1'b0);
        end

        cur_start = 8'h20;
        // R4 R3 full-word remap write, upper bits of each half ignored
        map_write(3, 32'hABCD_1234, 2'b11);
        scan_line(6, "R3", 1'b0);
        scan_line(7, "R4", 1'b0);
        // R4 upper half only
        map_write(3, 32'h0011_7777, 2'b10);
        scan_line(6, "R4", 1'b0);
        scan_line(7, "R4", 1'b0);
        // R3 high buffer line number
        map_write(100, 32'h0000_07FF, 2'b01);
        scan_line(200, "R3", 1'b0);
        // R7 request during a line is ignored
        scan_line(2, "R7", 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule